// File: doc/BRIEF.md
# Dual-Rate Token Bucket Shaper

This block limits the transmit rate of one scheduling node with two token buckets. One tracks a committed rate and the other a peak rate. Each bucket has its own configuration: a refill mantissa and exponent, a divider exponent that sets how often the refill happens, and a mantissa and exponent for the burst cap. Bucket levels are signed and kept in units of 1/256, so fractional refill amounts are never lost. Levels are updated only by refills and by packet deductions.

A packet-length request arrives on a valid/ready handshake. A request is accepted while the peak bucket is not in deficit. Accepting it takes the length from both buckets in the same cycle, and either bucket may go negative. One cycle after acceptance, the block raises a grant pulse. With the grant it raises a flag that tells whether the committed bucket was still non-negative before the deduction, so that the packet counts as within the committed rate. When the shaper is disabled, every request is granted at once and the buckets are frozen.

The refill interval is a base tick count shifted left by the divider exponent. The base is 240 cycles when the node sits at the top hierarchy level and 860 cycles for any lower level. The choice is made by a parameter.

Top module: `dual_rate_shaper`

## Requirements
- R1: After a synchronous reset, both levels equal 512 (two units, the cap for an all-zero configuration), `grant` and `grant_committed` are low and `req_ready` is high.
- R2: A configuration write to a bucket loads that bucket's level with its cap, ((256 + burst mantissa) << (burst exponent + 1)) in 1/256 units, and restarts its interval counter.
- R3: Each refill event adds (256 + rate mantissa) << rate exponent to the level, in 1/256 units. Fractional parts are kept: mantissa 1 with exponent 0 adds 257.
- R4: The first refill lands exactly (BASE << divider exponent) cycles after the configuration write, and later refills follow at the same spacing. BASE is 240 at the top level and 860 otherwise, and the divider exponent runs from 0 to 12.
- R5: While enabled, `req_ready` is high exactly when the peak level is non-negative. An accepted request gives a one-cycle `grant` on the next cycle. A request offered while the peak bucket is in deficit is not granted and changes neither level.
- R6: An accepted request subtracts 256 × length from both levels in the same cycle, and the result may be negative.
- R7: `grant_committed` rises with `grant` when the committed level was non-negative just before the deduction, and is low otherwise.
- R8: A level never exceeds its cap. A refill that would pass the cap, with or without a deduction in the same cycle, leaves the level at the cap.
- R9: While `enable` is low, `req_ready` is high, every request is granted on the next cycle, and both levels stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Shaping on; when low, requests pass and the buckets freeze |
| cfg_wr_cir | input | 1 | Write the cfg_* fields into the committed bucket |
| cfg_wr_pir | input | 1 | Write the cfg_* fields into the peak bucket |
| cfg_rate_man | input | 8 | Refill mantissa |
| cfg_rate_exp | input | 4 | Refill exponent |
| cfg_div_exp | input | 4 | Interval divider exponent (0..12) |
| cfg_burst_man | input | 8 | Burst cap mantissa |
| cfg_burst_exp | input | 4 | Burst cap exponent |
| req_valid | input | 1 | Packet request valid |
| req_len | input | LEN_W | Packet length in units |
| req_ready | output | 1 | Request may be accepted this cycle |
| grant | output | 1 | One-cycle pulse after an accepted request |
| grant_committed | output | 1 | Granted packet was within the committed rate |
| cir_level | output | LVL_W | Committed level, signed, 1/256 units |
| pir_level | output | LVL_W | Peak level, signed, 1/256 units |

## Verification
A configuration write and an accepted request both show their effect on the levels and on `grant`/`grant_committed` just after the very next clock edge. `req_ready` follows the peak level on the same cycle as a level change. A refill shows up exactly N = BASE << divider clock edges after the write edge. The bench therefore counts edges from each write and samples one time unit after an edge. It checks the level both one edge before and on the refill edge, so a refill that comes one cycle early or late fails.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

  localparam int NUM_BUCKETS = 2;
  localparam int CIR_IDX     = 0;
  localparam int PIR_IDX     = 1;
  localparam int MAX_DIV     = 12;
  localparam int CODE_W      = 25;

  typedef struct packed {
    logic [7:0] rate_man;
    logic [3:0] rate_exp;
    logic [3:0] div_exp;
    logic [7:0] burst_man;
    logic [3:0] burst_exp;
  } shp_cfg_t;

  // burst cap in 1/256 units: (256+m) << (e+1)
  function automatic logic [CODE_W-1:0] cap_q8(input logic [7:0] m, input logic [3:0] e);
    logic [CODE_W-1:0] base;
    base = {{(CODE_W-9){1'b0}}, 1'b1, m};
    return base << ({1'b0, e} + 5'd1);
  endfunction

  // refill amount in 1/256 units: (256+m) << e
  function automatic logic [CODE_W-1:0] refill_q8(input logic [7:0] m, input logic [3:0] e);
    logic [CODE_W-1:0] base;
    base = {{(CODE_W-9){1'b0}}, 1'b1, m};
    return base << e;
  endfunction

endpackage

// File: rtl/shaper_interval.sv
module shaper_interval #(
  parameter int BASE_TICKS = 240,
  parameter int MAX_DIV    = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       run,
  input  logic [3:0] div_exp,
  output logic       tick
);
  localparam int CNT_W = $clog2((BASE_TICKS << MAX_DIV) + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [3:0]       eff_div;

  always_comb begin
    eff_div = (div_exp > 4'(MAX_DIV)) ? 4'(MAX_DIV) : div_exp;
    last    = (CNT_W'(BASE_TICKS) << eff_div) - CNT_W'(1);
    tick    = run && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == last) cnt <= '0;
      else             cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/shaper_bucket.sv
module shaper_bucket
  import shaper_pkg::*;
#(
  parameter int LVL_W      = 28,
  parameter int LEN_W      = 16,
  parameter int BASE_TICKS = 240
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    cfg_wr,
  input  shp_cfg_t                cfg_in,
  input  logic                    take,
  input  logic [LEN_W-1:0]        take_len,
  output logic signed [LVL_W-1:0] level
);
  localparam int EXT_W = LVL_W + 2;
  localparam logic signed [EXT_W-1:0] FLOOR = {{3{1'b1}}, {(LVL_W-1){1'b0}}};

  shp_cfg_t                cfg_q;
  logic                    tick;
  logic signed [EXT_W-1:0] cap_s;
  logic signed [EXT_W-1:0] add_s;
  logic signed [EXT_W-1:0] sub_s;
  logic signed [EXT_W-1:0] sum_s;
  logic signed [EXT_W-1:0] nxt_s;

  shaper_interval #(
    .BASE_TICKS(BASE_TICKS),
    .MAX_DIV   (MAX_DIV)
  ) u_interval (
    .clk    (clk),
    .rst    (rst),
    .restart(cfg_wr),
    .run    (run),
    .div_exp(cfg_q.div_exp),
    .tick   (tick)
  );

  always_comb begin
    cap_s = $signed({{(EXT_W-CODE_W){1'b0}}, cap_q8(cfg_q.burst_man, cfg_q.burst_exp)});
    add_s = tick ? $signed({{(EXT_W-CODE_W){1'b0}}, refill_q8(cfg_q.rate_man, cfg_q.rate_exp)})
                 : '0;
    sub_s = take ? $signed({{(EXT_W-LEN_W-8){1'b0}}, take_len, 8'd0}) : '0;
    sum_s = $signed({{2{level[LVL_W-1]}}, level}) + add_s - sub_s;
    if (sum_s > cap_s)      nxt_s = cap_s;
    else if (sum_s < FLOOR) nxt_s = FLOOR;
    else                    nxt_s = sum_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      level <= LVL_W'(cap_q8(8'd0, 4'd0));
    end else if (cfg_wr) begin
      cfg_q <= cfg_in;
      level <= LVL_W'(cap_q8(cfg_in.burst_man, cfg_in.burst_exp));
    end else if (run) begin
      level <= nxt_s[LVL_W-1:0];
    end
  end
endmodule

// File: rtl/dual_rate_shaper.sv
module dual_rate_shaper
  import shaper_pkg::*;
#(
  parameter bit TOP_LEVEL      = 1'b1,
  parameter int TOP_BASE_TICKS = 240,
  parameter int LOW_BASE_TICKS = 860,
  parameter int LEN_W          = 16,
  parameter int LVL_W          = 28
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    cfg_wr_cir,
  input  logic                    cfg_wr_pir,
  input  logic [7:0]              cfg_rate_man,
  input  logic [3:0]              cfg_rate_exp,
  input  logic [3:0]              cfg_div_exp,
  input  logic [7:0]              cfg_burst_man,
  input  logic [3:0]              cfg_burst_exp,
  input  logic                    req_valid,
  input  logic [LEN_W-1:0]        req_len,
  output logic                    req_ready,
  output logic                    grant,
  output logic                    grant_committed,
  output logic signed [LVL_W-1:0] cir_level,
  output logic signed [LVL_W-1:0] pir_level
);
  localparam int BASE_TICKS = TOP_LEVEL ? TOP_BASE_TICKS : LOW_BASE_TICKS;

  shp_cfg_t                cfg_word;
  logic [NUM_BUCKETS-1:0]  wr_vec;
  logic signed [LVL_W-1:0] lvl [NUM_BUCKETS];
  logic                    fire;
  logic                    take;

  assign cfg_word = '{rate_man:  cfg_rate_man,  rate_exp:  cfg_rate_exp,
                      div_exp:   cfg_div_exp,
                      burst_man: cfg_burst_man, burst_exp: cfg_burst_exp};
  assign wr_vec[CIR_IDX] = cfg_wr_cir;
  assign wr_vec[PIR_IDX] = cfg_wr_pir;

  assign req_ready = !enable || (lvl[PIR_IDX] >= 0);
  assign fire      = req_valid && req_ready;
  assign take      = fire && enable;

  for (genvar gi = 0; gi < NUM_BUCKETS; gi++) begin : g_bucket
    shaper_bucket #(
      .LVL_W     (LVL_W),
      .LEN_W     (LEN_W),
      .BASE_TICKS(BASE_TICKS)
    ) u_bucket (
      .clk     (clk),
      .rst     (rst),
      .run     (enable),
      .cfg_wr  (wr_vec[gi]),
      .cfg_in  (cfg_word),
      .take    (take),
      .take_len(req_len),
      .level   (lvl[gi])
    );
  end

  assign cir_level = lvl[CIR_IDX];
  assign pir_level = lvl[PIR_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      grant           <= 1'b0;
      grant_committed <= 1'b0;
    end else begin
      grant           <= fire;
      grant_committed <= fire && (lvl[CIR_IDX] >= 0);
    end
  end
endmodule

// File: rtl/dual_rate_shaper_chk.sv
module dual_rate_shaper_chk #(
  parameter int LVL_W = 28
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enable,
  input logic                    cfg_wr_cir,
  input logic                    cfg_wr_pir,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    grant,
  input logic                    grant_committed,
  input logic signed [LVL_W-1:0] cir_level,
  input logic signed [LVL_W-1:0] pir_level
);
  AST_GRANT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> grant); // R5

  AST_NO_GRANT_IN_DEFICIT: assert property (@(posedge clk) disable iff (rst)
    (enable && (pir_level < 0)) |=> !grant); // R5

  AST_COMMIT_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
    grant_committed |-> grant); // R7

  AST_COMMIT_PRIOR_LEVEL: assert property (@(posedge clk) disable iff (rst)
    grant_committed |-> ($past(cir_level) >= 0)); // R7

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!enable && !cfg_wr_cir && !cfg_wr_pir) |=> ($stable(cir_level) && $stable(pir_level))); // R9

  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (rst)
    (!enable && req_valid) |=> grant); // R9
endmodule

bind dual_rate_shaper dual_rate_shaper_chk #(.LVL_W(LVL_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .enable         (enable),
  .cfg_wr_cir     (cfg_wr_cir),
  .cfg_wr_pir     (cfg_wr_pir),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .grant          (grant),
  .grant_committed(grant_committed),
  .cir_level      (cir_level),
  .pir_level      (pir_level)
);

// File: tb/dual_rate_shaper_test.sv
`timescale 1ns/1ps
module dual_rate_shaper_test;
  localparam int LEN_W = 16;
  localparam int LVL_W = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic cfg_wr_cir = 1'b0, cfg_wr_pir = 1'b0;
  logic [7:0] cfg_rate_man = '0, cfg_burst_man = '0;
  logic [3:0] cfg_rate_exp = '0, cfg_div_exp = '0, cfg_burst_exp = '0;
  logic req_valid = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, grant, grant_committed;
  logic signed [LVL_W-1:0] cir_level, pir_level;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dual_rate_shaper #(.TOP_LEVEL(1'b1), .LEN_W(LEN_W), .LVL_W(LVL_W)) uut (
    .clk(clk), .rst(rst), .enable(enable),
    .cfg_wr_cir(cfg_wr_cir), .cfg_wr_pir(cfg_wr_pir),
    .cfg_rate_man(cfg_rate_man), .cfg_rate_exp(cfg_rate_exp), .cfg_div_exp(cfg_div_exp),
    .cfg_burst_man(cfg_burst_man), .cfg_burst_exp(cfg_burst_exp),
    .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready),
    .grant(grant), .grant_committed(grant_committed),
    .cir_level(cir_level), .pir_level(pir_level)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input bit peak, input int m, input int e, input int d,
                           input int bm, input int be);
    cfg_rate_man = 8'(m); cfg_rate_exp = 4'(e); cfg_div_exp = 4'(d);
    cfg_burst_man = 8'(bm); cfg_burst_exp = 4'(be);
    cfg_wr_pir = peak; cfg_wr_cir = !peak;
    step(1);
    cfg_wr_pir = 1'b0; cfg_wr_cir = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    check("R1 cir level", cir_level, 512);
    check("R1 pir level", pir_level, 512);
    check("R1 grant", grant, 0);
    check("R1 committed", grant_committed, 0);
    check("R1 ready", req_ready, 1);
  endtask

  // edge k: peak write, edge k+1: committed write
  task automatic t_refill_grant;
    write_cfg(1'b1, 1, 0, 1, 64, 5);
    write_cfg(1'b0, 0, 8, 0, 0, 9);
    check("R2 pir cap", pir_level, 20480);
    check("R2 cir cap", cir_level, 262144);
    req_valid = 1'b1; req_len = 16'd100;
    check("R5 ready at cap", req_ready, 1);
    step(1);                                  // after k+2
    req_valid = 1'b0;
    check("R5 grant", grant, 1);
    check("R7 committed", grant_committed, 1);
    check("R6 pir deficit", pir_level, -5120);
    check("R6 cir deduct", cir_level, 236544);
    check("R5 ready in deficit", req_ready, 0);
    req_valid = 1'b1; req_len = 16'd5;
    step(10);                                 // after k+12
    check("R5 no grant in deficit", grant, 0);
    check("R5 pir unchanged", pir_level, -5120);
    check("R5 cir unchanged", cir_level, 236544);
    req_valid = 1'b0;
    step(467);                                // after k+479
    check("R4 no early refill", pir_level, -5120);
    check("R8 cir clamped at cap", cir_level, 262144);
    step(1);                                  // after k+480
    check("R3 fractional refill", pir_level, -4863);
    step(479);                                // after k+959
    check("R4 no early second refill", pir_level, -4863);
    step(1);                                  // after k+960
    check("R4 second refill", pir_level, -4606);
  endtask

  task automatic t_disabled;
    enable = 1'b0;
    #1;
    check("R9 ready while off", req_ready, 1);
    req_valid = 1'b1; req_len = 16'd1000;
    step(1);
    req_valid = 1'b0;
    check("R9 grant while off", grant, 1);
    check("R9 pir frozen", pir_level, -4606);
    check("R9 cir frozen", cir_level, 262144);
    step(300);
    check("R9 pir frozen long", pir_level, -4606);
    enable = 1'b1;
  endtask

  // edge j: peak write, j+1: committed write
  task automatic t_committed;
    write_cfg(1'b1, 255, 15, 0, 255, 15);
    write_cfg(1'b0, 0, 0, 12, 0, 0);
    check("R2 pir max cap", pir_level, 33488896);
    check("R2 cir min cap", cir_level, 512);
    req_valid = 1'b1; req_len = 16'd10;
    step(1);                                  // j+2
    check("R7 committed while nonneg", grant_committed, 1);
    check("R6 cir below zero", cir_level, -2048);
    step(1);                                  // j+3
    req_valid = 1'b0;
    check("R5 grant second", grant, 1);
    check("R7 not committed in deficit", grant_committed, 0);
    check("R6 cir deeper", cir_level, -4608);
    check("R6 pir both deducted", pir_level, 33483776);
    step(237);                                // j+240
    check("R8 max refill clamps", pir_level, 33488896);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_refill_grant();
    t_disabled();
    t_committed();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule